// File: doc/BRIEF.md
# Priority Reference Selector with Revertivity

This block picks which of twelve timing references drives one clock generator. Each candidate carries a qualified flag and a 4-bit priority. The block registers the winning index and a valid flag, and it raises a one-cycle pulse whenever the index moves. A clock-generation subsystem places one instance per generator, and each instance has its own priority table.

In manual mode the index comes straight from a control input, and qualification plays no part. In automatic mode the index is the best-ranked eligible reference. Priority value 1 ranks highest, 15 ranks lowest, and 0 takes a reference out of the automatic choice. A revert control decides whether a better reference that becomes eligible may displace a current reference that is still eligible. When nothing is eligible, the last index is held and the valid flag drops.

Top module: `ref_pick_top`

## Requirements
- R1: While rst_ni is low, active_idx_o is 0, active_valid_o is 0 and switch_o is 0.
- R2: With auto_mode_i low and manual_idx_i below 12, the next clock edge loads active_idx_o with manual_idx_i and sets active_valid_o to 1, whatever qual_i holds.
- R3: With auto_mode_i low and manual_idx_i of 12 or more, the next edge keeps active_idx_o unchanged and clears active_valid_o.
- R4: In automatic mode, reference i is eligible only if qual_i[i] is 1 and its priority field prio_i[4*i+3:4*i] is nonzero. A qualified reference whose field is 0 is never chosen.
- R5: With auto_mode_i and revert_i high and at least one reference eligible, the next edge selects the eligible reference with the smallest nonzero priority value. Among equal values the lowest index wins, and active_valid_o is 1.
- R6: With auto_mode_i high and revert_i low, if active_valid_o is 1 and the current reference is still eligible, the index stays the same even when a better eligible reference exists.
- R7: With auto_mode_i high and revert_i low, if the current reference is not eligible or active_valid_o is 0, the next edge takes the reference that R5 would select, when one exists.
- R8: In automatic mode with no eligible reference, the next edge holds active_idx_o and clears active_valid_o.
- R9: switch_o is 1 for exactly the cycle in which active_idx_o shows a value different from the previous cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qual_i | input | 12 | Qualified flag per reference |
| prio_i | input | 48 | Priority table, 4 bits per reference, reference i at bits 4*i+3:4*i |
| auto_mode_i | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| revert_i | input | 1 | 1 enables revertive behaviour in automatic mode |
| manual_idx_i | input | 4 | Reference index used in manual mode |
| active_idx_o | output | 4 | Registered active reference index |
| active_valid_o | output | 1 | Active index is usable |
| switch_o | output | 1 | One-cycle pulse when the active index changes |

## Verification
All three outputs come from one register stage. An input pattern sampled at a rising edge therefore shows on active_idx_o, active_valid_o and switch_o right after that edge, and switch_o is compared against the index that was shown one cycle earlier. The bench changes inputs on the falling edge and computes the next expected state from the inputs it has just applied and its own copy of the previous state. It compares that state at the following falling edge, so every comparison looks exactly one edge after its stimulus. The non-revertive checks depend on this carried state, because whether a reference is kept depends on the index chosen in the previous cycle.

// File: rtl/ref_pick_pkg.sv
package ref_pick_pkg;
  localparam int unsigned NUM_REFS_DEF = 12;
  localparam int unsigned PRIO_W_DEF   = 4;

  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_MANUAL = 2'd1,
    SEL_KEEP   = 2'd2,
    SEL_BEST   = 2'd3
  } sel_kind_e;
endpackage

// File: rtl/ref_elig.sv
module ref_elig #(
  parameter int unsigned NUM_REFS = 12,
  parameter int unsigned PRIO_W   = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REFS)
) (
  input  logic [NUM_REFS-1:0]        qual_i,
  input  logic [NUM_REFS*PRIO_W-1:0] prio_i,
  input  logic [IDX_W-1:0]           cur_idx_i,
  input  logic                       cur_valid_i,
  output logic [NUM_REFS-1:0]        elig_o,
  output logic                       cur_ok_o
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REFS);

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_elig
    assign elig_o[g] = qual_i[g] && (prio_i[g*PRIO_W +: PRIO_W] != '0);
  end

  logic cur_in_range;
  assign cur_in_range = {1'b0, cur_idx_i} < NUM_L;
  assign cur_ok_o     = cur_valid_i && cur_in_range && elig_o[cur_idx_i];
endmodule

// File: rtl/ref_prio_search.sv
module ref_prio_search #(
  parameter int unsigned NUM_REFS = 12,
  parameter int unsigned PRIO_W   = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REFS)
) (
  input  logic [NUM_REFS-1:0]        elig_i,
  input  logic [NUM_REFS*PRIO_W-1:0] prio_i,
  output logic                       any_o,
  output logic [IDX_W-1:0]           best_idx_o
);
  logic [NUM_REFS:0] fnd;
  logic [IDX_W-1:0]  idx_c [NUM_REFS+1];
  logic [PRIO_W-1:0] pr_c  [NUM_REFS+1];

  assign fnd[0]   = 1'b0;
  assign idx_c[0] = '0;
  assign pr_c[0]  = '1;

  // strict compare: an earlier index keeps a tie
  for (genvar g = 0; g < NUM_REFS; g++) begin : g_stage
    logic [PRIO_W-1:0] p;
    logic              take;
    assign p          = prio_i[g*PRIO_W +: PRIO_W];
    assign take       = elig_i[g] && (!fnd[g] || (p < pr_c[g]));
    assign fnd[g+1]   = fnd[g] | elig_i[g];
    assign idx_c[g+1] = take ? IDX_W'(g) : idx_c[g];
    assign pr_c[g+1]  = take ? p : pr_c[g];
  end

  assign any_o      = fnd[NUM_REFS];
  assign best_idx_o = idx_c[NUM_REFS];
endmodule

// File: rtl/ref_pick_ctrl.sv
module ref_pick_ctrl
  import ref_pick_pkg::*;
#(
  parameter int unsigned NUM_REFS = 12,
  localparam int unsigned IDX_W   = $clog2(NUM_REFS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_mode_i,
  input  logic             revert_i,
  input  logic [IDX_W-1:0] manual_idx_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] best_idx_i,
  input  logic             cur_ok_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             switch_o
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REFS);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d, switch_q;
  sel_kind_e        kind;

  always_comb begin
    if (!auto_mode_i) begin
      kind = ({1'b0, manual_idx_i} < NUM_L) ? SEL_MANUAL : SEL_HOLD;
    end else if (!revert_i && cur_ok_i) begin
      kind = SEL_KEEP;
    end else if (any_i) begin
      kind = SEL_BEST;
    end else begin
      kind = SEL_HOLD;
    end
  end

  always_comb begin
    idx_d   = idx_q;
    valid_d = 1'b0;
    unique case (kind)
      SEL_MANUAL: begin idx_d = manual_idx_i; valid_d = 1'b1; end
      SEL_KEEP:   begin idx_d = idx_q;        valid_d = 1'b1; end
      SEL_BEST:   begin idx_d = best_idx_i;   valid_d = 1'b1; end
      default:    begin idx_d = idx_q;        valid_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      valid_q  <= 1'b0;
      switch_q <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      valid_q  <= valid_d;
      switch_q <= (idx_d != idx_q);
    end
  end

  assign idx_o    = idx_q;
  assign valid_o  = valid_q;
  assign switch_o = switch_q;
endmodule

// File: rtl/ref_pick_top.sv
module ref_pick_top #(
  parameter int unsigned NUM_REFS = ref_pick_pkg::NUM_REFS_DEF,
  parameter int unsigned PRIO_W   = ref_pick_pkg::PRIO_W_DEF,
  localparam int unsigned IDX_W   = $clog2(NUM_REFS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REFS-1:0]        qual_i,
  input  logic [NUM_REFS*PRIO_W-1:0] prio_i,
  input  logic                       auto_mode_i,
  input  logic                       revert_i,
  input  logic [IDX_W-1:0]           manual_idx_i,
  output logic [IDX_W-1:0]           active_idx_o,
  output logic                       active_valid_o,
  output logic                       switch_o
);
  logic [NUM_REFS-1:0] elig;
  logic                cur_ok, any;
  logic [IDX_W-1:0]    best_idx;

  ref_elig #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_elig (
    .qual_i      (qual_i),
    .prio_i      (prio_i),
    .cur_idx_i   (active_idx_o),
    .cur_valid_i (active_valid_o),
    .elig_o      (elig),
    .cur_ok_o    (cur_ok)
  );

  ref_prio_search #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_search (
    .elig_i     (elig),
    .prio_i     (prio_i),
    .any_o      (any),
    .best_idx_o (best_idx)
  );

  ref_pick_ctrl #(.NUM_REFS(NUM_REFS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_mode_i  (auto_mode_i),
    .revert_i     (revert_i),
    .manual_idx_i (manual_idx_i),
    .any_i        (any),
    .best_idx_i   (best_idx),
    .cur_ok_i     (cur_ok),
    .idx_o        (active_idx_o),
    .valid_o      (active_valid_o),
    .switch_o     (switch_o)
  );
endmodule

// File: rtl/ref_pick_chk.sv
module ref_pick_chk #(
  parameter int unsigned NUM_REFS = 12,
  parameter int unsigned PRIO_W   = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REFS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_REFS-1:0]        qual_i,
  input logic [NUM_REFS*PRIO_W-1:0] prio_i,
  input logic                       auto_mode_i,
  input logic                       revert_i,
  input logic [IDX_W-1:0]           manual_idx_i,
  input logic [IDX_W-1:0]           active_idx_o,
  input logic                       active_valid_o,
  input logic                       switch_o
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REFS);

  logic [NUM_REFS-1:0]        e_now, e_r;
  logic [NUM_REFS*PRIO_W-1:0] p_r;
  logic                       auto_r, rev_r;
  logic                       better_r;

  always_comb begin
    for (int j = 0; j < NUM_REFS; j++)
      e_now[j] = qual_i[j] && (prio_i[j*PRIO_W +: PRIO_W] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_r <= '0; p_r <= '0; auto_r <= 1'b0; rev_r <= 1'b0;
    end else begin
      e_r <= e_now; p_r <= prio_i; auto_r <= auto_mode_i; rev_r <= revert_i;
    end
  end

  // an eligible reference ranked above the shown index, using last cycle's table
  always_comb begin
    better_r = 1'b0;
    for (int j = 0; j < NUM_REFS; j++) begin
      if (e_r[j] && ({1'b0, active_idx_o} < NUM_L)) begin
        if ((p_r[j*PRIO_W +: PRIO_W] < p_r[active_idx_o*PRIO_W +: PRIO_W]) ||
            ((p_r[j*PRIO_W +: PRIO_W] == p_r[active_idx_o*PRIO_W +: PRIO_W]) &&
             (IDX_W'(j) < active_idx_o)))
          better_r = 1'b1;
      end
    end
  end

  a_r2_manual_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_mode_i && ({1'b0, manual_idx_i} < NUM_L)) |=>
      (active_valid_o && active_idx_o == $past(manual_idx_i)));

  a_r3_manual_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_mode_i && ({1'b0, manual_idx_i} >= NUM_L)) |=>
      (!active_valid_o && $stable(active_idx_o)));

  a_r5_revert_best: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_r && rev_r && (e_r != '0)) |->
      (active_valid_o && e_r[active_idx_o] && !better_r));

  a_r6_keep_current: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && !revert_i && active_valid_o && e_now[active_idx_o]) |=>
      (active_valid_o && $stable(active_idx_o)));

  a_r8_none_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && (e_now == '0)) |=> (!active_valid_o && $stable(active_idx_o)));

  a_r9_switch_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> (active_idx_o != $past(active_idx_o)));

  a_r9_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !switch_o |-> $stable(active_idx_o));
endmodule

bind ref_pick_top ref_pick_chk #(.NUM_REFS(NUM_REFS), .PRIO_W(PRIO_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .qual_i         (qual_i),
  .prio_i         (prio_i),
  .auto_mode_i    (auto_mode_i),
  .revert_i       (revert_i),
  .manual_idx_i   (manual_idx_i),
  .active_idx_o   (active_idx_o),
  .active_valid_o (active_valid_o),
  .switch_o       (switch_o)
);

// File: tb/sim_ref_pick_top.sv
`timescale 1ns/1ps
module sim_ref_pick_top;
  localparam int N  = 12;
  localparam int PW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  qual = '0;
  logic [N*PW-1:0] prio = '0;
  logic          auto_m = 1'b0, revert = 1'b0;
  logic [IW-1:0] man = '0;
  logic [IW-1:0] idx;
  logic          valid, sw;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [IW-1:0] e_idx = '0;
  logic          e_valid = 1'b0;

  always #2 clk = ~clk;

  ref_pick_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .qual_i(qual), .prio_i(prio),
    .auto_mode_i(auto_m), .revert_i(revert), .manual_idx_i(man),
    .active_idx_o(idx), .active_valid_o(valid), .switch_o(sw)
  );

  function automatic logic [PW-1:0] pr(input logic [N*PW-1:0] t, input int i);
    return t[i*PW +: PW];
  endfunction

  function automatic logic elig(input int i);
    return qual[i] && (pr(prio, i) != 0);
  endfunction

  // returns {found, index}
  function automatic logic [IW:0] best_ref();
    logic f = 1'b0; int b = 0;
    for (int i = 0; i < N; i++)
      if (elig(i) && (!f || pr(prio, i) < pr(prio, b))) begin f = 1'b1; b = i; end
    return {f, IW'(b)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // inputs are already applied; model one edge, check at the next falling edge
  task automatic step();
    logic [IW-1:0] n_idx; logic n_v; logic e_sw; string tag;
    logic [IW:0] bb = best_ref();
    n_idx = e_idx; n_v = 1'b0;
    if (!auto_m) begin
      if (man < N) begin n_idx = man; n_v = 1'b1; tag = "R2"; end
      else tag = "R3";
    end else if (!revert && e_valid && elig(int'(e_idx))) begin
      n_v = 1'b1; tag = "R6";
    end else if (bb[IW]) begin
      n_idx = bb[IW-1:0]; n_v = 1'b1; tag = revert ? "R5" : "R7";
    end else tag = "R8";
    e_sw = (n_idx != e_idx);
    e_idx = n_idx; e_valid = n_v;
    @(negedge clk);
    chk(idx == e_idx, tag, "index", idx, e_idx);
    chk(valid == e_valid, tag, "valid", valid, e_valid);
    chk(sw == e_sw, "R9", "switch", sw, e_sw);
  endtask

  function automatic logic [N*PW-1:0] set_pr(input logic [N*PW-1:0] t, input int i, input int v);
    t[i*PW +: PW] = PW'(v);
    return t;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(idx == 0, "R1", "reset index", idx, 0);
    chk(valid == 0, "R1", "reset valid", valid, 0);
    chk(sw == 0, "R1", "reset switch", sw, 0);
    rst_n = 1'b1;

    // manual, ignores qualification
    man = 5; qual = '0; step();
    man = 13; step();
    man = 15; step();
    // automatic revertive: ref1 excluded by priority 0, tie 3 vs 7
    prio = '0;
    prio = set_pr(prio, 1, 0); prio = set_pr(prio, 3, 2);
    prio = set_pr(prio, 7, 2); prio = set_pr(prio, 9, 5);
    prio = set_pr(prio, 0, 1);
    qual = 12'b0010_1000_1010;
    auto_m = 1'b1; revert = 1'b1; step();
    chk(idx != 1, "R4", "priority-0 ref chosen", idx, 3);
    // only ref1 qualified (priority 0): nothing eligible
    qual = 12'b0000_0000_0010; step();
    chk(valid == 0, "R4", "priority-0 ref valid", valid, 0);
    // non-revertive: hold 3 while better ref0 appears
    qual = 12'b0010_1000_1000; revert = 1'b0; step();
    qual = 12'b0010_1000_1001; step(); step();
    qual = 12'b0010_1000_0001; step();
    qual = '0; step();
    revert = 1'b1; qual = 12'b0010_0000_0000; step();
    qual = 12'b0010_0000_0001; step();

    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 16 == 0)
        for (int i = 0; i < N; i++) prio = set_pr(prio, i, int'($urandom % 16));
      for (int i = 0; i < N; i++) if ($urandom % 8 == 0) qual[i] = ~qual[i];
      if ($urandom % 20 == 0) auto_m = ($urandom % 6) != 0;
      if ($urandom % 30 == 0) revert = ~revert;
      man = IW'($urandom % 16);
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule